// File: doc/BRIEF.md
# Dual-Register Shifter with Fill and Index Control

This block shifts a pair of 24-bit registers, A and B, by a signed amount under a packed control word. The control word selects the nominal direction, logical or arithmetic mode, which registers take part, and what enters the vacated positions. The registers can move as one 48-bit unit with A in the upper half, as A alone, as B alone, or as two independent 24-bit units. The vacated bits can receive zeros, ones, the bits leaving the opposite end, or the complement of those bits.

The count is a small signed value. It can be offset by an index register, so a program can compute the shift distance at run time. A negative effective count turns the shift the other way. On arithmetic shifts that move toward the sign end, the block reports whether the sign of A took any other value at any step of the shift. The control word arrives already decoded. Results, including the overflow pulse, are registered and appear one clock after the operands are sampled.

Top module: `dual_reg_shifter`

## Requirements
- R1: While rst_ni is low, a_o, b_o and ovf_o are zero. Otherwise every clock edge loads the result for the inputs present at that edge, so each result appears one cycle after its inputs.
- R2: spec_i is packed as follows. Bit 12 is the direction (0 left, 1 right). Bit 11 is the mode (0 logical, 1 arithmetic). Bits 10:9 are the register select. Bits 8:7 are the fill code. Bits 6:0 are a two's-complement count.
- R3: Select 0 shifts {A,B} as one 48-bit value with A as the upper half. Select 1 shifts A only and leaves B unchanged. Select 2 shifts B only and leaves A unchanged. Select 3 shifts A and B as two separate 24-bit values.
- R4: Fill code 0 inserts zeros and fill code 1 inserts ones. A magnitude equal to or larger than the unit width leaves only fill bits in that unit.
- R5: Fill code 2 rotates, inserting the bits that leave the opposite end. Fill code 3 inserts the complements of those bits. For both codes the magnitude is reduced modulo the unit width.
- R6: When the effective count is negative, the direction in bit 12 is reversed and the absolute value is used as the magnitude.
- R7: When idx_en_i is 1, the effective count is the count sign-extended to 24 bits plus idx_i, taken modulo 2^24 and read as a signed value. When idx_en_i is 0, idx_i has no effect.
- R8: An arithmetic shift whose effective direction is right keeps each unit's sign bit in place. The positions vacated below it receive the sign for fill codes 0, 1 and 2, and the complement of the sign for fill code 3. A magnitude of width−1 or more leaves only those fill bits below the sign.
- R9: ovf_o is 1 after an arithmetic shift with effective direction left that includes A, if the sign bit of A held a value different from its original value after any single step of the shift. ovf_o is 0 after logical shifts, after shifts with effective direction right, and after select 2.
- R10: An effective count of zero returns A and B unchanged and ovf_o at 0, for every select and fill code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 24 | Register A operand |
| b_i | input | 24 | Register B operand |
| spec_i | input | 13 | Packed shift control word |
| idx_en_i | input | 1 | Add idx_i to the count |
| idx_i | input | 24 | Index register value |
| a_o | output | 24 | Shifted A |
| b_o | output | 24 | Shifted B |
| ovf_o | output | 1 | Overflow set by this operation |

## Verification
Operands that straddle the A/B boundary are shifted under the joined select and under the split select. Comparing the two results shows whether bits cross between the registers. Counts below, at and beyond the unit width are applied under every fill code, which separates saturating fills from the modulo reduction used by the rotating codes. Negative counts, and index values that push the effective count across zero, confirm the direction reversal and the index sum. An arithmetic left shift of A whose sign flips at an intermediate step and then returns to its original value shows that every step is checked for overflow, not only the final result. A long run of random vectors is then compared each cycle against a step-by-step behavioural model.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int REG_W  = 24;
  localparam int CNT_W  = 7;
  localparam int SPEC_W = 6 + CNT_W;

  typedef enum logic [1:0] {
    SEL_JOIN  = 2'd0,
    SEL_A     = 2'd1,
    SEL_B     = 2'd2,
    SEL_SPLIT = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_ONE  = 2'd1,
    FILL_ROT  = 2'd2,
    FILL_NROT = 2'd3
  } fill_e;

  typedef struct packed {
    logic             dir;
    logic             arith;
    sel_e             sel;
    fill_e            fill;
    logic [CNT_W-1:0] cnt;
  } spec_t;
endpackage

// File: rtl/shf_count.sv
module shf_count #(
  parameter int CNT_W = 7,
  parameter int REG_W = 24
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_i,
  input  logic             idx_en_i,
  input  logic [REG_W-1:0] idx_i,
  output logic             right_o,
  output logic [REG_W-1:0] mag_o
);
  logic [REG_W-1:0] ext, eff;
  logic             neg;

  assign ext     = {{(REG_W-CNT_W){cnt_i[CNT_W-1]}}, cnt_i};
  assign eff     = ext + (idx_en_i ? idx_i : '0);
  assign neg     = eff[REG_W-1];
  assign mag_o   = neg ? (~eff + 1'b1) : eff;
  assign right_o = dir_i ^ neg;
endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter int W     = 24,
  parameter int MAG_W = 24
) (
  input  logic [W-1:0]     x_i,
  input  logic             right_i,
  input  logic             arith_i,
  input  fill_e            fill_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             ovf_en_i,
  output logic [W-1:0]     y_o,
  output logic             ovf_o
);
  localparam int SW = $clog2(W + 1);

  logic [SW-1:0]    sat_amt, rot_amt, amt;
  logic             rotating, sbit, ins, hit;
  logic [W-1:0]     fw, y_left, y_right, y_ar;
  logic [2*W-1:0]   lcat, rcat, l_res, r_res, t;
  logic [2*W-2:0]   acat, a_res;

  assign sat_amt  = (mag_i >= MAG_W'(W)) ? SW'(W) : mag_i[SW-1:0];
  assign rot_amt  = SW'(mag_i % MAG_W'(W));
  assign rotating = (fill_i == FILL_ROT || fill_i == FILL_NROT) && !(arith_i && right_i);
  assign amt      = rotating ? rot_amt : sat_amt;

  always_comb begin
    unique case (fill_i)
      FILL_ZERO: fw = '0;
      FILL_ONE:  fw = '1;
      FILL_ROT:  fw = x_i;
      default:   fw = ~x_i;
    endcase
  end

  // fill word sits beyond the end that is being vacated
  assign lcat    = {x_i, fw};
  assign rcat    = {fw, x_i};
  assign l_res   = lcat << amt;
  assign r_res   = rcat >> amt;
  assign y_left  = l_res[2*W-1:W];
  assign y_right = r_res[W-1:0];

  assign sbit  = x_i[W-1];
  assign ins   = (fill_i == FILL_NROT) ? ~sbit : sbit;
  assign acat  = {{W{ins}}, x_i[W-2:0]};
  assign a_res = acat >> amt;
  assign y_ar  = {sbit, a_res[W-2:0]};

  assign y_o = right_i ? (arith_i ? y_ar : y_right) : y_left;

  // step j puts bit 2W-1-j of lcat into the sign position
  assign t = lcat ^ {(2*W){sbit}};
  always_comb begin
    hit = 1'b0;
    for (int j = 1; j <= W; j++) begin
      if (j <= int'(amt) && t[2*W-1-j]) hit = 1'b1;
    end
  end
  assign ovf_o = ovf_en_i && !right_i && hit;
endmodule

// File: rtl/dual_reg_shifter.sv
module dual_reg_shifter
  import shf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_W-1:0]  a_i,
  input  logic [REG_W-1:0]  b_i,
  input  logic [SPEC_W-1:0] spec_i,
  input  logic              idx_en_i,
  input  logic [REG_W-1:0]  idx_i,
  output logic [REG_W-1:0]  a_o,
  output logic [REG_W-1:0]  b_o,
  output logic              ovf_o
);
  spec_t              spec;
  logic               right;
  logic [REG_W-1:0]   mag;
  logic [2*REG_W-1:0] y_join;
  logic               ovf_join;
  logic [1:0][REG_W-1:0] reg_in, y_sep;
  logic [1:0]         ovf_sep;
  logic [REG_W-1:0]   a_nxt, b_nxt;
  logic               ovf_nxt;

  assign spec      = spec_t'(spec_i);
  assign reg_in[0] = a_i;
  assign reg_in[1] = b_i;

  shf_count #(.CNT_W(CNT_W), .REG_W(REG_W)) u_count (
    .cnt_i   (spec.cnt),
    .dir_i   (spec.dir),
    .idx_en_i(idx_en_i),
    .idx_i   (idx_i),
    .right_o (right),
    .mag_o   (mag)
  );

  shf_unit #(.W(2*REG_W), .MAG_W(REG_W)) u_join (
    .x_i     ({a_i, b_i}),
    .right_i (right),
    .arith_i (spec.arith),
    .fill_i  (spec.fill),
    .mag_i   (mag),
    .ovf_en_i(spec.arith),
    .y_o     (y_join),
    .ovf_o   (ovf_join)
  );

  for (genvar g = 0; g < 2; g++) begin : g_sep
    logic ovf_en;
    assign ovf_en = (g == 0) ? spec.arith : 1'b0;  // only A reports overflow
    shf_unit #(.W(REG_W), .MAG_W(REG_W)) u_sep (
      .x_i     (reg_in[g]),
      .right_i (right),
      .arith_i (spec.arith),
      .fill_i  (spec.fill),
      .mag_i   (mag),
      .ovf_en_i(ovf_en),
      .y_o     (y_sep[g]),
      .ovf_o   (ovf_sep[g])
    );
  end

  always_comb begin
    unique case (spec.sel)
      SEL_JOIN: begin a_nxt = y_join[2*REG_W-1:REG_W]; b_nxt = y_join[REG_W-1:0]; ovf_nxt = ovf_join;   end
      SEL_A:    begin a_nxt = y_sep[0];                b_nxt = b_i;               ovf_nxt = ovf_sep[0]; end
      SEL_B:    begin a_nxt = a_i;                     b_nxt = y_sep[1];          ovf_nxt = ovf_sep[1]; end
      default:  begin a_nxt = y_sep[0];                b_nxt = y_sep[1];          ovf_nxt = |ovf_sep;   end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o   <= '0;
      b_o   <= '0;
      ovf_o <= 1'b0;
    end else begin
      a_o   <= a_nxt;
      b_o   <= b_nxt;
      ovf_o <= ovf_nxt;
    end
  end

  a_r3_b_only_keeps_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec.sel == SEL_B |=> a_o == $past(a_i));
  a_r3_a_only_keeps_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec.sel == SEL_A |=> b_o == $past(b_i));
  a_r9_logical_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spec.arith |=> !ovf_o);
  a_r9_b_only_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec.sel == SEL_B |=> !ovf_o);
  a_r8_arith_right_keeps_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec.arith && right && spec.sel != SEL_B |=> a_o[REG_W-1] == $past(a_i[REG_W-1]));
  a_r10_zero_count_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag == '0 |=> a_o == $past(a_i) && b_o == $past(b_i) && !ovf_o);
endmodule

// File: tb/sim_dual_reg_shifter.sv
module sim_dual_reg_shifter;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] a_i = '0, b_i = '0, idx_i = '0;
  logic [12:0] spec_i = '0;
  logic        idx_en_i = 1'b0;
  logic [23:0] a_o, b_o;
  logic        ovf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  dual_reg_shifter u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [12:0] mk(bit dir, bit ar, int sel, int fl, int cnt);
    logic [6:0] c = 7'(cnt);
    return {dir, ar, 2'(sel), 2'(fl), c};
  endfunction

  task automatic unit_ref(input int n, input logic [47:0] x, input bit right, input bit ar,
                          input int fl, input int mag, output logic [47:0] y, output bit ov);
    int steps;
    logic [47:0] v = x;
    logic sign = x[n-1], outb, ins;
    ov = 0;
    if (fl >= 2 && !(ar && right)) steps = mag % n;
    else steps = (mag > n) ? n : mag;
    for (int i = 0; i < steps; i++) begin
      if (right && ar) begin
        ins = (fl == 3) ? ~sign : sign;
        for (int k = 0; k < n-2; k++) v[k] = v[k+1];
        v[n-2] = ins;
      end else if (right) begin
        outb = v[0];
        ins = (fl == 0) ? 1'b0 : (fl == 1) ? 1'b1 : (fl == 2) ? outb : ~outb;
        for (int k = 0; k < n-1; k++) v[k] = v[k+1];
        v[n-1] = ins;
      end else begin
        outb = v[n-1];
        ins = (fl == 0) ? 1'b0 : (fl == 1) ? 1'b1 : (fl == 2) ? outb : ~outb;
        for (int k = n-1; k > 0; k--) v[k] = v[k-1];
        v[0] = ins;
        if (v[n-1] != sign) ov = 1;
      end
    end
    y = v;
  endtask

  task automatic model(input logic [23:0] a, input logic [23:0] b, input logic [12:0] sp,
                       input bit ien, input logic [23:0] idx,
                       output logic [23:0] ea, output logic [23:0] eb, output bit eo);
    int ev, mag, sel, fl;
    bit right, ar, ov0, ov1;
    logic [47:0] y0, y1;
    ev = int'($signed(sp[6:0]));
    if (ien) ev = ev + int'(idx);
    ev = ev & 32'h00FF_FFFF;
    if (ev >= 32'h0080_0000) ev = ev - 32'h0100_0000;
    mag   = (ev < 0) ? -ev : ev;
    right = sp[12] ^ (ev < 0);
    ar    = sp[11];
    sel   = int'(sp[10:9]);
    fl    = int'(sp[8:7]);
    ea = a; eb = b; eo = 0;
    case (sel)
      0: begin unit_ref(48, {a, b}, right, ar, fl, mag, y0, ov0);
               ea = y0[47:24]; eb = y0[23:0]; eo = ov0; end
      1: begin unit_ref(24, {24'd0, a}, right, ar, fl, mag, y0, ov0); ea = y0[23:0]; eo = ov0; end
      2: begin unit_ref(24, {24'd0, b}, right, ar, fl, mag, y1, ov1); eb = y1[23:0]; end
      default: begin
        unit_ref(24, {24'd0, a}, right, ar, fl, mag, y0, ov0);
        unit_ref(24, {24'd0, b}, right, ar, fl, mag, y1, ov1);
        ea = y0[23:0]; eb = y1[23:0]; eo = ov0;
      end
    endcase
    eo = eo && ar && !right;
  endtask

  // called at a negedge: drive, let one edge load, check at the next negedge
  task automatic apply(input string tag, input logic [12:0] sp, input bit ien,
                       input logic [23:0] idx, input logic [23:0] a, input logic [23:0] b);
    logic [23:0] ea, eb;
    bit eo;
    a_i = a; b_i = b; spec_i = sp; idx_en_i = ien; idx_i = idx;
    model(a, b, sp, ien, idx, ea, eb, eo);
    @(posedge clk_i);
    @(negedge clk_i);
    n_chk++;
    if (a_o !== ea || b_o !== eb || ovf_o !== eo) begin
      n_fail++;
      $display("FAIL %s: spec=%h a=%h b=%h ovf=%b expected a=%h b=%h ovf=%b",
               tag, sp, a_o, b_o, ovf_o, ea, eb, eo);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    a_i = 24'hABCDEF; b_i = 24'h123456; spec_i = mk(0, 1, 0, 1, 5);
    repeat (3) begin
      @(negedge clk_i);
      n_chk++;
      if (a_o !== '0 || b_o !== '0 || ovf_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R1: reset a=%h b=%h ovf=%b expected 0 0 0", a_o, b_o, ovf_o);
      end
    end
    rst_ni = 1'b1;

    apply("R1", mk(0, 0, 1, 0, 1), 0, 0, 24'h000001, 24'h000002);
    apply("R2", mk(0, 0, 1, 0, 4), 0, 0, 24'h123456, 24'h654321);
    apply("R2", mk(1, 0, 1, 0, 8), 0, 0, 24'h123456, 24'h654321);
    apply("R3", mk(0, 0, 0, 0, 12), 0, 0, 24'h00000F, 24'hF00000);
    apply("R3", mk(0, 0, 3, 0, 12), 0, 0, 24'h00000F, 24'hF00000);
    apply("R3", mk(1, 0, 2, 1, 3), 0, 0, 24'hFFFFFF, 24'h000F00);
    apply("R4", mk(1, 0, 1, 1, 5), 0, 0, 24'h000000, 24'h777777);
    apply("R4", mk(0, 0, 1, 0, 63), 0, 0, 24'hFFFFFF, 24'h111111);
    apply("R4", mk(0, 0, 0, 1, 50), 0, 0, 24'h000000, 24'h000000);
    apply("R4", mk(1, 0, 3, 0, 24), 0, 0, 24'hFFFFFF, 24'hFFFFFF);
    apply("R5", mk(0, 0, 1, 2, 30), 0, 0, 24'hC00001, 24'h0);
    apply("R5", mk(1, 0, 3, 3, 3), 0, 0, 24'h000005, 24'h800000);
    apply("R5", mk(0, 0, 0, 2, 47), 0, 0, 24'h800000, 24'h000001);
    apply("R5", mk(0, 0, 0, 3, 48), 0, 0, 24'h5A5A5A, 24'h0F0F0F);
    apply("R6", mk(0, 0, 1, 0, -5), 0, 0, 24'h0000F0, 24'h0);
    apply("R6", mk(1, 0, 0, 2, -64), 0, 0, 24'h123456, 24'h789ABC);
    apply("R7", mk(0, 0, 1, 0, -3), 1, 24'd10, 24'h000001, 24'h0);
    apply("R7", mk(0, 0, 3, 2, 1), 1, 24'd1000, 24'h123456, 24'hABCDEF);
    apply("R7", mk(0, 0, 1, 0, 5), 1, 24'hFFFFF0, 24'h800000, 24'h0);
    apply("R7", mk(0, 0, 1, 0, 2), 0, 24'h000777, 24'h000003, 24'h0);
    apply("R8", mk(1, 1, 1, 0, 4), 0, 0, 24'h800001, 24'h0);
    apply("R8", mk(1, 1, 1, 3, 4), 0, 0, 24'h800001, 24'h0);
    apply("R8", mk(1, 1, 0, 2, 40), 0, 0, 24'h812345, 24'h6789AB);
    apply("R8", mk(1, 1, 3, 3, 30), 0, 0, 24'h400000, 24'h800000);
    apply("R9", mk(0, 1, 1, 0, 2), 0, 0, 24'h400000, 24'h0);
    apply("R9", mk(0, 1, 1, 0, 1), 0, 0, 24'h200000, 24'h0);
    apply("R9", mk(0, 0, 1, 0, 2), 0, 0, 24'h400000, 24'h0);
    apply("R9", mk(0, 1, 2, 0, 2), 0, 0, 24'h400000, 24'h400000);
    apply("R9", mk(0, 1, 0, 2, 24), 0, 0, 24'h000000, 24'h000010);
    apply("R9", mk(1, 1, 3, 0, -1), 0, 0, 24'h400000, 24'h0);
    apply("R10", mk(0, 1, 0, 3, 0), 0, 0, 24'h9ABCDE, 24'h135790);
    apply("R10", mk(1, 0, 3, 1, 4), 1, 24'hFFFFFC, 24'h2468AC, 24'hFEDCBA);

    for (int i = 0; i < 600; i++) begin
      logic [12:0] sp = 13'($urandom);
      bit ien = ($urandom % 4) == 0;
      logic [23:0] idx = (($urandom % 2) == 0) ? 24'($urandom % 128) : 24'(-($urandom % 128));
      apply("R3 random", sp, ien, idx, 24'($urandom), 24'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule